// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small, fully associative store of recent virtual-to-physical page translations. Each slot holds a virtual page tag, the physical page it maps to, a page-size code, three attribute fields (execute-never, a 2-bit access-permission code and shareable), a not-global flag, and the address space, virtual machine and security-space identifiers that were current when the translation was made. A slot can describe a 4 KB, 64 KB, 1 MB or 16 MB page. Slots of different sizes sit side by side, and each slot masks the low page-number bits that its own size covers.

A requester presents a virtual address together with its current address space ID, virtual machine ID and security space. One clock later the block returns hit or miss, the translated physical address and the attributes. On a miss, the external page-table walker writes the result through the refill port. The victim slot is the lowest free slot, or a rotating pointer once every slot is in use. Three maintenance inputs remove translations: clear everything, clear the slots that cover an address, or clear the process-private slots of one address space ID. Permission checking and the table walk sit outside this block.

Top module: `tlb_tagged`

## Requirements
- R1: After reset, all slots are invalid and `rs_valid`, `rs_hit` and `rs_multi` are 0. Any lookup misses until a refill takes place.
- R2: On a hit, `rs_pa` is the stored physical page number with the bits the page size covers taken from the request address, and `rs_xn`/`rs_ap`/`rs_sh` equal the stored attributes. With size shift S = 12 + 4*size, the result is `rs_pa = (stored_pa & ~(2^S-1)) | (lk_va & (2^S-1))`.
- R3: Size code 0 means 4 KB, 1 means 64 KB, 2 means 1 MB and 3 means 16 MB. A slot matches any `lk_va` whose bits [31:S] equal its tag bits [31:S]. The low page-number bits given at refill are ignored.
- R4: A hit needs `lk_vmid` equal to the stored VMID and `lk_space` equal to the stored security space.
- R5: The ASID takes part in matching only when the slot is not-global (`rf_ng`=1). A global slot matches under any `lk_asid`.
- R6: Two slots for the same virtual page with different ASIDs coexist. Each returns its own physical page, and neither counts as a multiple hit for the other.
- R7: When more than one slot matches, `rs_multi` is 1, `rs_hit` is 1 and the result comes from the lowest-index matching slot. A refill never merges with an existing slot.
- R8: A refill goes into the lowest-index invalid slot. When all slots are valid, it goes into the slot named by a rotating pointer that starts at 0 after reset and advances by one (wrapping) only on such a refill.
- R9: `inv_all` clears every slot at the next clock edge.
- R10: Invalidate-by-address (`inv_va_en`) clears each valid slot whose tag covers `inv_vpn` under that slot's own size. A global slot is cleared under any `inv_asid`. A not-global slot is cleared only when its ASID equals `inv_asid`. VMID and space are not compared.
- R11: Invalidate-by-ASID (`inv_asid_en`) clears only not-global slots whose ASID equals `inv_asid`. Global slots and other ASIDs survive.
- R12: In a cycle where any invalidate input is high, the refill request is dropped.
- R13: The lookup result is registered. `rs_valid` is `lk_valid` delayed by one clock. A lookup sees the table as it was before the clock edge that ends its cycle, so a refill in the same cycle is not visible to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | ASID_W | Current address space ID |
| lk_vmid | input | VMID_W | Current virtual machine ID |
| lk_space | input | SPACE_W | Current security/privilege space |
| rs_valid | output | 1 | Result of last cycle's lookup is present |
| rs_hit | output | 1 | Lookup hit |
| rs_multi | output | 1 | More than one slot matched |
| rs_pa | output | PA_W | Translated physical address |
| rs_xn | output | 1 | Execute-never attribute |
| rs_ap | output | 2 | Access permission code |
| rs_sh | output | 1 | Shareable attribute |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 20 | Virtual page number (address bits 31:12) |
| rf_ppn | input | PA_W-12 | Physical page number |
| rf_size | input | 2 | Page size code |
| rf_xn | input | 1 | Execute-never to store |
| rf_ap | input | 2 | Access permission to store |
| rf_sh | input | 1 | Shareable to store |
| rf_ng | input | 1 | Not-global flag to store |
| rf_asid | input | ASID_W | ASID to store |
| rf_vmid | input | VMID_W | VMID to store |
| rf_space | input | SPACE_W | Security space to store |
| inv_all | input | 1 | Invalidate every slot |
| inv_va_en | input | 1 | Invalidate by address |
| inv_asid_en | input | 1 | Invalidate by ASID |
| inv_vpn | input | 20 | Page number for invalidate-by-address |
| inv_asid | input | ASID_W | ASID for both selective invalidates |

## Verification
Translation is swept over all four size codes. For each size, eight probe offsets inside the page are tried, along with the first address above the page and the last address below it. These tell correct masking of tag and physical bits apart from masking at the wrong boundary. Context matching is swept over every combination of matching and mismatching ASID, VMID and space, for both a not-global and a global slot. This separates the ASID exemption of global slots from the VMID and space checks, which always apply. Ordering-sensitive patterns cover the rest:
- duplicate refills, which expose the lowest-index rule;
- a full-table refill sequence, which exposes the free-slot preference against the rotating pointer;
- selective invalidates aimed next to surviving slots;
- refills and lookups issued in the same cycle as invalidates or as each other.

// File: rtl/tlb_tagged_pkg.sv
package tlb_tagged_pkg;
  localparam int VA_W      = 32;
  localparam int MIN_SHIFT = 12;
  localparam int VPN_W     = VA_W - MIN_SHIFT;
  localparam int SIZE_STEP = 4;   // each size code widens the page by 2^4

  // Page-number bits that still take part in a compare for a given size code
  function automatic logic [VPN_W-1:0] vpn_keep_mask(input logic [1:0] sz);
    return {VPN_W{1'b1}} << (SIZE_STEP * sz);
  endfunction
endpackage

// File: rtl/tlb_tagged_cmp.sv
module tlb_tagged_cmp
  import tlb_tagged_pkg::*;
#(
  parameter int ASID_W  = 8,
  parameter int VMID_W  = 8,
  parameter int SPACE_W = 2
) (
  input  logic               e_vld,
  input  logic [VPN_W-1:0]   e_tag,
  input  logic [1:0]         e_size,
  input  logic               e_ng,
  input  logic [ASID_W-1:0]  e_asid,
  input  logic [VMID_W-1:0]  e_vmid,
  input  logic [SPACE_W-1:0] e_space,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [VMID_W-1:0]  lk_vmid,
  input  logic [SPACE_W-1:0] lk_space,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic [ASID_W-1:0]  inv_asid,
  output logic               lk_hit,
  output logic               inv_va_hit,
  output logic               inv_asid_hit
);
  logic [VPN_W-1:0] keep;
  logic lk_tag_eq, inv_tag_eq, lk_asid_ok, inv_asid_ok;

  always_comb begin
    keep        = vpn_keep_mask(e_size);
    lk_tag_eq   = ((e_tag ^ lk_vpn) & keep) == '0;
    inv_tag_eq  = ((e_tag ^ inv_vpn) & keep) == '0;
    lk_asid_ok  = !e_ng || (e_asid == lk_asid);
    inv_asid_ok = !e_ng || (e_asid == inv_asid);
    lk_hit      = e_vld && lk_tag_eq && lk_asid_ok &&
                  (e_vmid == lk_vmid) && (e_space == lk_space);
    inv_va_hit   = e_vld && inv_tag_eq && inv_asid_ok;
    inv_asid_hit = e_vld && e_ng && (e_asid == inv_asid);
  end
endmodule

// File: rtl/tlb_tagged_prio.sv
module tlb_tagged_prio #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    any   = |vec;
    multi = |(vec & (vec - N'(1)));
  end
endmodule

// File: rtl/tlb_tagged_victim.sv
module tlb_tagged_victim #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     vld,
  input  logic             alloc,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] ptr_q, ptr_d, free_idx;
  logic             free_found;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    idx   = free_found ? free_idx : ptr_q;
    ptr_d = ptr_q;
    if (alloc && !free_found) begin
      ptr_d = (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
  import tlb_tagged_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int PA_W        = 32,
  parameter int ASID_W      = 8,
  parameter int VMID_W      = 8,
  parameter int SPACE_W     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_va,
  input  logic [ASID_W-1:0]       lk_asid,
  input  logic [VMID_W-1:0]       lk_vmid,
  input  logic [SPACE_W-1:0]      lk_space,
  output logic                    rs_valid,
  output logic                    rs_hit,
  output logic                    rs_multi,
  output logic [PA_W-1:0]         rs_pa,
  output logic                    rs_xn,
  output logic [1:0]              rs_ap,
  output logic                    rs_sh,
  input  logic                    rf_valid,
  input  logic [VPN_W-1:0]        rf_vpn,
  input  logic [PA_W-MIN_SHIFT-1:0] rf_ppn,
  input  logic [1:0]              rf_size,
  input  logic                    rf_xn,
  input  logic [1:0]              rf_ap,
  input  logic                    rf_sh,
  input  logic                    rf_ng,
  input  logic [ASID_W-1:0]       rf_asid,
  input  logic [VMID_W-1:0]       rf_vmid,
  input  logic [SPACE_W-1:0]      rf_space,
  input  logic                    inv_all,
  input  logic                    inv_va_en,
  input  logic                    inv_asid_en,
  input  logic [VPN_W-1:0]        inv_vpn,
  input  logic [ASID_W-1:0]       inv_asid
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int PPN_W = PA_W - MIN_SHIFT;

  // slot storage
  logic [NUM_ENTRIES-1:0] vld_q, vld_d;
  logic [VPN_W-1:0]   tag_q   [NUM_ENTRIES];
  logic [PPN_W-1:0]   ppn_q   [NUM_ENTRIES];
  logic [1:0]         size_q  [NUM_ENTRIES];
  logic               xn_q    [NUM_ENTRIES];
  logic [1:0]         ap_q    [NUM_ENTRIES];
  logic               sh_q    [NUM_ENTRIES];
  logic               ng_q    [NUM_ENTRIES];
  logic [ASID_W-1:0]  asid_q  [NUM_ENTRIES];
  logic [VMID_W-1:0]  vmid_q  [NUM_ENTRIES];
  logic [SPACE_W-1:0] space_q [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] lk_vec, inv_va_vec, inv_asid_vec;
  logic [VPN_W-1:0] lk_vpn;
  logic             inv_any, wr_en;
  logic [IDX_W-1:0] wr_idx, hit_idx;
  logic             hit_any, hit_multi;

  assign lk_vpn  = lk_va[VA_W-1:MIN_SHIFT];
  assign inv_any = inv_all | inv_va_en | inv_asid_en;
  assign wr_en   = rf_valid & ~inv_any;

  generate
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
      tlb_tagged_cmp #(
        .ASID_W(ASID_W), .VMID_W(VMID_W), .SPACE_W(SPACE_W)
      ) u_cmp (
        .e_vld       (vld_q[g]),
        .e_tag       (tag_q[g]),
        .e_size      (size_q[g]),
        .e_ng        (ng_q[g]),
        .e_asid      (asid_q[g]),
        .e_vmid      (vmid_q[g]),
        .e_space     (space_q[g]),
        .lk_vpn      (lk_vpn),
        .lk_asid     (lk_asid),
        .lk_vmid     (lk_vmid),
        .lk_space    (lk_space),
        .inv_vpn     (inv_vpn),
        .inv_asid    (inv_asid),
        .lk_hit      (lk_vec[g]),
        .inv_va_hit  (inv_va_vec[g]),
        .inv_asid_hit(inv_asid_vec[g])
      );
    end
  endgenerate

  tlb_tagged_prio #(.N(NUM_ENTRIES)) u_prio (
    .vec  (lk_vec),
    .idx  (hit_idx),
    .any  (hit_any),
    .multi(hit_multi)
  );

  tlb_tagged_victim #(.N(NUM_ENTRIES)) u_victim (
    .clk  (clk),
    .rst_n(rst_n),
    .vld  (vld_q),
    .alloc(wr_en),
    .idx  (wr_idx)
  );

  // valid bits: invalidates win over refill
  always_comb begin
    vld_d = vld_q;
    if (inv_all) begin
      vld_d = '0;
    end else begin
      if (inv_va_en)   vld_d = vld_d & ~inv_va_vec;
      if (inv_asid_en) vld_d = vld_d & ~inv_asid_vec;
      if (wr_en)       vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // slot payload: written with an explicit enable, not reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        tag_q[i]   <= rf_vpn;
        ppn_q[i]   <= rf_ppn;
        size_q[i]  <= rf_size;
        xn_q[i]    <= rf_xn;
        ap_q[i]    <= rf_ap;
        sh_q[i]    <= rf_sh;
        ng_q[i]    <= rf_ng;
        asid_q[i]  <= rf_asid;
        vmid_q[i]  <= rf_vmid;
        space_q[i] <= rf_space;
      end
    end
  end

  // result formation
  logic [VPN_W-1:0] sel_keep;
  logic [PPN_W-1:0] sel_ppn_keep, pa_ppn;
  logic [PA_W-1:0]  pa_d;
  logic             rs_hit_d, rs_multi_d, rs_en;

  always_comb begin
    sel_keep     = vpn_keep_mask(size_q[hit_idx]);
    sel_ppn_keep = {PPN_W{1'b1}} << (SIZE_STEP * size_q[hit_idx]);
    pa_ppn       = (ppn_q[hit_idx] & sel_ppn_keep) | PPN_W'(lk_vpn & ~sel_keep);
    pa_d         = {pa_ppn, lk_va[MIN_SHIFT-1:0]};
    rs_hit_d     = lk_valid & hit_any;
    rs_multi_d   = lk_valid & hit_multi;
    rs_en        = lk_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_multi <= 1'b0;
      rs_pa    <= '0;
      rs_xn    <= 1'b0;
      rs_ap    <= '0;
      rs_sh    <= 1'b0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= rs_hit_d;
      rs_multi <= rs_multi_d;
      if (rs_en) begin
        rs_pa <= pa_d;
        rs_xn <= xn_q[hit_idx];
        rs_ap <= ap_q[hit_idx];
        rs_sh <= sh_q[hit_idx];
      end
    end
  end
endmodule

// File: rtl/tlb_tagged_chk.sv
module tlb_tagged_chk
  import tlb_tagged_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ASID_W      = 8,
  parameter int VMID_W      = 8,
  parameter int SPACE_W     = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [VPN_W-1:0]       lk_vpn,
  input logic [ASID_W-1:0]      lk_asid,
  input logic [VMID_W-1:0]      lk_vmid,
  input logic [SPACE_W-1:0]     lk_space,
  input logic                   rs_valid,
  input logic                   rs_hit,
  input logic                   rs_multi,
  input logic                   rf_valid,
  input logic [VPN_W-1:0]       rf_vpn,
  input logic [ASID_W-1:0]      rf_asid,
  input logic [VMID_W-1:0]      rf_vmid,
  input logic [SPACE_W-1:0]     rf_space,
  input logic                   inv_all,
  input logic                   inv_va_en,
  input logic                   inv_asid_en,
  input logic [NUM_ENTRIES-1:0] entry_vld
);
  logic               fill_q, wipe_q;
  logic [VPN_W-1:0]   f_vpn;
  logic [ASID_W-1:0]  f_asid;
  logic [VMID_W-1:0]  f_vmid;
  logic [SPACE_W-1:0] f_space;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
      wipe_q <= 1'b0;
    end else begin
      fill_q <= rf_valid && !inv_all && !inv_va_en && !inv_asid_en;
      wipe_q <= inv_all;
    end
  end

  always_ff @(posedge clk) begin
    f_vpn   <= rf_vpn;
    f_asid  <= rf_asid;
    f_vmid  <= rf_vmid;
    f_space <= rf_space;
  end

  // R13
  rs_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  // R13
  rs_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  // R7
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_multi |-> (rs_hit && rs_valid));
  // R9
  inv_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (entry_vld == '0));
  // R9
  miss_after_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_q && lk_valid) |=> !rs_hit);
  // R8
  refill_takes_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !inv_all && !inv_va_en && !inv_asid_en && !(&entry_vld))
    |=> ($countones(entry_vld) == $past($countones(entry_vld)) + 1));
  // R12
  inv_blocks_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && (inv_va_en || inv_asid_en))
    |=> ($countones(entry_vld) <= $past($countones(entry_vld))));
  // R2
  refill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q && lk_valid && lk_vpn == f_vpn && lk_asid == f_asid &&
     lk_vmid == f_vmid && lk_space == f_space) |=> rs_hit);
endmodule

bind tlb_tagged tlb_tagged_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .ASID_W(ASID_W), .VMID_W(VMID_W), .SPACE_W(SPACE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_vpn     (lk_va[31:12]),
  .lk_asid    (lk_asid),
  .lk_vmid    (lk_vmid),
  .lk_space   (lk_space),
  .rs_valid   (rs_valid),
  .rs_hit     (rs_hit),
  .rs_multi   (rs_multi),
  .rf_valid   (rf_valid),
  .rf_vpn     (rf_vpn),
  .rf_asid    (rf_asid),
  .rf_vmid    (rf_vmid),
  .rf_space   (rf_space),
  .inv_all    (inv_all),
  .inv_va_en  (inv_va_en),
  .inv_asid_en(inv_asid_en),
  .entry_vld  (vld_q)
);

// File: tb/tlb_tagged_bench.sv
`timescale 1ns/1ps
module tlb_tagged_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid, lk_vmid;
  logic [1:0]  lk_space;
  logic        rs_valid, rs_hit, rs_multi;
  logic [31:0] rs_pa;
  logic        rs_xn, rs_sh;
  logic [1:0]  rs_ap;
  logic        rf_valid;
  logic [19:0] rf_vpn, rf_ppn;
  logic [1:0]  rf_size, rf_ap, rf_space;
  logic        rf_xn, rf_sh, rf_ng;
  logic [7:0]  rf_asid, rf_vmid;
  logic        inv_all, inv_va_en, inv_asid_en;
  logic [19:0] inv_vpn;
  logic [7:0]  inv_asid;

  tlb_tagged u_tlb_tagged (.*);

  int n_run = 0;
  int n_fail = 0;
  logic        g_valid, g_hit, g_multi, g_xn, g_sh;
  logic [31:0] g_pa;
  logic [1:0]  g_ap;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pa(input logic [31:0] va,
                                         input logic [31:0] pa, input int sz);
    logic [31:0] m;
    m = (32'h1 << (12 + 4 * sz)) - 32'h1;
    return (pa & ~m) | (va & m);
  endfunction

  task automatic set_refill(input logic [31:0] va, input logic [31:0] pa,
                            input int sz, input logic xn, input logic [1:0] ap,
                            input logic sh, input logic ng, input logic [7:0] asid,
                            input logic [7:0] vmid, input logic [1:0] sp);
    rf_vpn = va[31:12]; rf_ppn = pa[31:12]; rf_size = 2'(sz);
    rf_xn = xn; rf_ap = ap; rf_sh = sh; rf_ng = ng;
    rf_asid = asid; rf_vmid = vmid; rf_space = sp; rf_valid = 1'b1;
  endtask

  task automatic refill(input logic [31:0] va, input logic [31:0] pa,
                        input int sz, input logic ng, input logic [7:0] asid);
    @(negedge clk);
    set_refill(va, pa, sz, 1'b0, 2'd1, 1'b0, ng, asid, 8'd2, 2'd0);
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic capture();
    g_valid = rs_valid; g_hit = rs_hit; g_multi = rs_multi;
    g_pa = rs_pa; g_xn = rs_xn; g_ap = rs_ap; g_sh = rs_sh;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid,
                      input logic [7:0] vmid, input logic [1:0] sp);
    @(negedge clk);
    lk_va = va; lk_asid = asid; lk_vmid = vmid; lk_space = sp; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    capture();
  endtask

  task automatic inv(input logic a, input logic v, input logic s,
                     input logic [31:0] va, input logic [7:0] asid);
    @(negedge clk);
    inv_all = a; inv_va_en = v; inv_asid_en = s; inv_vpn = va[31:12]; inv_asid = asid;
    @(negedge clk);
    inv_all = 1'b0; inv_va_en = 1'b0; inv_asid_en = 1'b0;
  endtask

  task automatic exp_hit(input string req, input logic [31:0] va,
                         input logic [7:0] asid, input logic [31:0] pa);
    look(va, asid, 8'd2, 2'd0);
    check(req, "hit", 32'(g_hit), 32'd1);
    check(req, "pa", g_pa, pa);
  endtask

  task automatic exp_miss(input string req, input logic [31:0] va, input logic [7:0] asid);
    look(va, asid, 8'd2, 2'd0);
    check(req, "hit", 32'(g_hit), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; lk_asid = '0; lk_vmid = '0; lk_space = '0;
    rf_valid = 1'b0; rf_vpn = '0; rf_ppn = '0; rf_size = '0; rf_xn = 1'b0; rf_ap = '0;
    rf_sh = 1'b0; rf_ng = 1'b0; rf_asid = '0; rf_vmid = '0; rf_space = '0;
    inv_all = 1'b0; inv_va_en = 1'b0; inv_asid_en = 1'b0; inv_vpn = '0; inv_asid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle outputs and an empty table
    check("R1", "rs_valid", 32'(rs_valid), 32'd0);
    check("R1", "rs_hit", 32'(rs_hit), 32'd0);
    check("R1", "rs_multi", 32'(rs_multi), 32'd0);
    exp_miss("R1", 32'h0000_0000, 8'd1);
    exp_miss("R1", 32'hFFFF_F123, 8'd1);

    // R2/R3: every size code, offsets inside and the neighbours outside
    for (int sz = 0; sz < 4; sz++) begin
      logic [31:0] base, pa, m;
      base = 32'h5A5A_5A5A; pa = 32'hC3C3_C3C3;
      m = (32'h1 << (12 + 4 * sz)) - 32'h1;
      inv(1'b1, 1'b0, 1'b0, '0, '0);
      @(negedge clk);
      set_refill(base, pa, sz, sz[0], 2'(sz), sz[1], 1'b1, 8'd1, 8'd2, 2'd0);
      @(negedge clk);
      rf_valid = 1'b0;
      for (int k = 0; k < 8; k++) begin
        logic [31:0] probe;
        probe = (base & ~m) | ((32'h9E37_79B9 * k) & m);
        look(probe, 8'd1, 8'd2, 2'd0);
        check("R3", "hit in page", 32'(g_hit), 32'd1);
        check("R2", "pa", g_pa, exp_pa(probe, pa, sz));
        check("R2", "xn", 32'(g_xn), 32'(sz & 1));
        check("R2", "ap", 32'(g_ap), 32'(sz));
        check("R2", "sh", 32'(g_sh), 32'((sz >> 1) & 1));
      end
      exp_miss("R3", (base & ~m) + (32'h1 << (12 + 4 * sz)), 8'd1);
      exp_miss("R3", (base & ~m) - 32'h1, 8'd1);
    end

    // R4/R5: context sweep on a not-global slot
    inv(1'b1, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    set_refill(32'h0040_0000, 32'h1110_0000, 0, 1'b0, 2'd0, 1'b0, 1'b1, 8'd3, 8'd5, 2'd1);
    @(negedge clk);
    rf_valid = 1'b0;
    for (int ia = 0; ia < 2; ia++)
      for (int iv = 0; iv < 2; iv++)
        for (int is = 0; is < 2; is++) begin
          look(32'h0040_0abc, 8'(3 + ia), 8'(5 + iv), 2'(1 + is));
          check((ia == 1 && iv == 0 && is == 0) ? "R5" : "R4", "ng context hit",
                32'(g_hit), 32'((ia == 0 && iv == 0 && is == 0) ? 1 : 0));
        end
    // R5: global slot ignores ASID, VMID and space still matter
    @(negedge clk);
    set_refill(32'h0080_0000, 32'h2220_0000, 0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd3, 8'd5, 2'd1);
    @(negedge clk);
    rf_valid = 1'b0;
    for (int a = 0; a < 8; a++) begin
      look(32'h0080_0010, 8'(a * 37), 8'd5, 2'd1);
      check("R5", "global any asid", 32'(g_hit), 32'd1);
    end
    look(32'h0080_0010, 8'd3, 8'd6, 2'd1);
    check("R4", "global vmid mismatch", 32'(g_hit), 32'd0);
    look(32'h0080_0010, 8'd3, 8'd5, 2'd0);
    check("R4", "global space mismatch", 32'(g_hit), 32'd0);

    // R6: same page, two ASIDs
    inv(1'b1, 1'b0, 1'b0, '0, '0);
    refill(32'h7000_0000, 32'hAAAA_0000, 0, 1'b1, 8'd1);
    refill(32'h7000_0000, 32'hBBBB_0000, 0, 1'b1, 8'd2);
    exp_hit("R6", 32'h7000_0123, 8'd1, 32'hAAAA_0123);
    check("R6", "no multi", 32'(g_multi), 32'd0);
    exp_hit("R6", 32'h7000_0123, 8'd2, 32'hBBBB_0123);
    exp_miss("R6", 32'h7000_0123, 8'd3);

    // R7: overlapping slots, lowest index wins
    inv(1'b1, 1'b0, 1'b0, '0, '0);
    refill(32'h6000_0000, 32'h1234_5000, 0, 1'b1, 8'd1);
    refill(32'h6000_0000, 32'h9870_0000, 2, 1'b1, 8'd1);
    exp_hit("R7", 32'h6000_0456, 8'd1, 32'h1234_5456);
    check("R7", "multi", 32'(g_multi), 32'd1);
    exp_hit("R7", 32'h6004_0456, 8'd1, 32'h9874_0456);
    check("R7", "single", 32'(g_multi), 32'd0);

    // R8: fill all slots, then rotation starting at slot 0
    inv(1'b1, 1'b0, 1'b0, '0, '0);
    for (int i = 0; i < N; i++) refill(32'(i) << 12, (32'h100 + 32'(i)) << 12, 0, 1'b1, 8'd1);
    refill(32'h0010_0000, 32'hE000_0000, 0, 1'b1, 8'd1);
    exp_miss("R8", 32'h0000_0000, 8'd1);
    exp_hit("R8", 32'h0000_1004, 8'd1, 32'h0010_1004);
    exp_hit("R8", 32'h0010_0008, 8'd1, 32'hE000_0008);
    refill(32'h0010_1000, 32'hE000_1000, 0, 1'b1, 8'd1);
    exp_miss("R8", 32'h0000_1000, 8'd1);
    exp_hit("R8", 32'h0000_2000, 8'd1, 32'h0010_2000);
    inv(1'b0, 1'b1, 1'b0, 32'h0000_5000, 8'd1);
    exp_miss("R10", 32'h0000_5000, 8'd1);
    refill(32'h0010_2000, 32'hE000_2000, 0, 1'b1, 8'd1);
    exp_hit("R8", 32'h0010_2000, 8'd1, 32'hE000_2000);
    exp_hit("R8", 32'h0000_2000, 8'd1, 32'h0010_2000);
    exp_hit("R8", 32'h0000_F000, 8'd1, 32'h0010_F000);

    // R9: invalidate everything
    inv(1'b1, 1'b0, 1'b0, '0, '0);
    exp_miss("R9", 32'h0000_2000, 8'd1);
    exp_miss("R9", 32'h0010_0000, 8'd1);
    exp_miss("R9", 32'h0000_F000, 8'd1);

    // R10: by address, size-aware, ASID only for not-global slots
    refill(32'h1000_0000, 32'h4000_0000, 2, 1'b1, 8'd7);
    refill(32'h2000_0000, 32'h5000_0000, 0, 1'b0, 8'd7);
    refill(32'h3000_0000, 32'h6000_0000, 0, 1'b1, 8'd7);
    inv(1'b0, 1'b1, 1'b0, 32'h100A_BCDE, 8'd9);
    exp_hit("R10", 32'h1001_2345, 8'd7, 32'h4001_2345);
    inv(1'b0, 1'b1, 1'b0, 32'h100A_BCDE, 8'd7);
    exp_miss("R10", 32'h1001_2345, 8'd7);
    exp_hit("R10", 32'h2000_0010, 8'd7, 32'h5000_0010);
    inv(1'b0, 1'b1, 1'b0, 32'h2000_0FFF, 8'd9);
    exp_miss("R10", 32'h2000_0010, 8'd7);
    exp_hit("R10", 32'h3000_0020, 8'd7, 32'h6000_0020);

    // R11: by ASID
    inv(1'b1, 1'b0, 1'b0, '0, '0);
    refill(32'h4000_0000, 32'h0A00_0000, 0, 1'b1, 8'd4);
    refill(32'h4100_0000, 32'h0B00_0000, 0, 1'b1, 8'd5);
    refill(32'h4200_0000, 32'h0C00_0000, 0, 1'b0, 8'd4);
    inv(1'b0, 1'b0, 1'b1, '0, 8'd4);
    exp_miss("R11", 32'h4000_0000, 8'd4);
    exp_hit("R11", 32'h4100_0004, 8'd5, 32'h0B00_0004);
    exp_hit("R11", 32'h4200_0008, 8'd4, 32'h0C00_0008);

    // R12: refill dropped under any invalidate
    @(negedge clk);
    set_refill(32'h5000_0000, 32'h0D00_0000, 0, 1'b0, 2'd0, 1'b0, 1'b1, 8'd1, 8'd2, 2'd0);
    inv_all = 1'b1;
    @(negedge clk);
    rf_valid = 1'b0; inv_all = 1'b0;
    exp_miss("R12", 32'h5000_0000, 8'd1);
    @(negedge clk);
    set_refill(32'h5100_0000, 32'h0E00_0000, 0, 1'b0, 2'd0, 1'b0, 1'b1, 8'd1, 8'd2, 2'd0);
    inv_asid_en = 1'b1; inv_asid = 8'hEE;
    @(negedge clk);
    rf_valid = 1'b0; inv_asid_en = 1'b0;
    exp_miss("R12", 32'h5100_0000, 8'd1);

    // R13: registered result; same-cycle refill not visible
    @(negedge clk);
    set_refill(32'h5200_0000, 32'h0F00_0000, 0, 1'b0, 2'd0, 1'b0, 1'b1, 8'd1, 8'd2, 2'd0);
    lk_va = 32'h5200_0000; lk_asid = 8'd1; lk_vmid = 8'd2; lk_space = 2'd0; lk_valid = 1'b1;
    @(negedge clk);
    rf_valid = 1'b0; lk_valid = 1'b0;
    capture();
    check("R13", "rs_valid", 32'(g_valid), 32'd1);
    check("R13", "same-cycle hit", 32'(g_hit), 32'd0);
    @(negedge clk);
    check("R13", "rs_valid idle", 32'(rs_valid), 32'd0);
    exp_hit("R13", 32'h5200_0ABC, 8'd1, 32'h0F00_0ABC);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule